// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits on the target side of a two-wire serial bus. It watches the clock and data lines, which are already synchronised to the kernel clock. It finds START and STOP conditions and collects the address byte or bytes that follow each START. It then decides whether this device is the one being addressed. Three kinds of first byte are recognised:

- the device's own address, in either a 7-bit or a 10-bit format, selected by configuration;
- the all-zero general call, which configuration can switch on or off;
- a high-speed master code.

For an address it accepts, the block pulls the data line low during the ninth clock, which is the acknowledge slot. It reports each outcome as a one-cycle event pulse and holds the read/write direction of the last matching address frame. Bit-rate generation, data buffering, master arbitration and clock stretching belong to other blocks. After the address phase, the recognizer stays quiet until the next START or STOP.

Top module: `i2c_addr_recog`

## Requirements
- R1: A falling data line while the clock is high is a START. It restarts address collection from the first bit. A rising data line while the clock is high is a STOP. It returns the block to idle and releases the data line.
- R2: In 7-bit mode (tenBitMode=0), a first byte whose upper seven bits equal ownAddr[6:0] is acknowledged. The block pulses addrMatch and sets readDir to bit 0 of that byte, where 1 means read.
- R3: In 10-bit mode, a first byte of 11110 followed by ownAddr[9:8] and a 0 direction bit is acknowledged without any event. A second byte equal to ownAddr[7:0] is then acknowledged with addrMatch and readDir=0. Any other second byte gets no acknowledge.
- R4: In 10-bit mode, after a full write match, a repeated START followed by the header byte with the direction bit set gives acknowledge, addrMatch and readDir=1. No second byte is needed. After a STOP this shortcut is not available, and the same byte gets no acknowledge.
- R5: With genCallEn=1, the first byte 0x00 is acknowledged and pulses genCallHit, not addrMatch. With genCallEn=0, the byte 0x00 gets no acknowledge and no event.
- R6: A first byte of the form 00001xxx pulses masterCodeHit and is never acknowledged.
- R7: sdaPullLow is asserted only in the acknowledge slot. It may start once the clock falls after the eighth bit and must end once the clock falls after the ninth.
- R8: Each event pulse lasts one cycle, and at most one event fires per address frame.
- R9: A repeated START in the middle of a byte throws away the partial byte. The next full byte is then recognised normally.
- R10: After reset, sdaPullLow, all event pulses and readDir are 0.
- R11: A first byte that is not recognised gets no acknowledge and no event. Later bytes are ignored until the next START, even if they equal the own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Synchronised bus clock line |
| sdaIn | input | 1 | Synchronised bus data line |
| ownAddr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| tenBitMode | input | 1 | 1 selects 10-bit own address |
| genCallEn | input | 1 | 1 enables general call recognition |
| sdaPullLow | output | 1 | Drive data line low (acknowledge) |
| addrMatch | output | 1 | One-cycle pulse on own-address match |
| genCallHit | output | 1 | One-cycle pulse on general call |
| masterCodeHit | output | 1 | One-cycle pulse on master code |
| readDir | output | 1 | Direction of last match, 1 = read |

## Verification
A wrong bit counter or a wrong shift alignment compares a misplaced byte. This shows up on the very next address frame as a missing acknowledge or a wrong event. The full sweep over all 256 first bytes exposes it within one transaction. A stuck control state either keeps sdaPullLow asserted outside the ninth clock or never asserts it, and the slot monitor catches this within a bit time. A wrongly kept or wrongly cleared 10-bit selection flag appears only on the repeated-START read, so the bench runs that read both right after a write match and after a STOP.

// File: rtl/i2c_arec_pkg.sv
package i2c_arec_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int PFX_W = 5;
  localparam logic [PFX_W-1:0] MCODE_PFX = 5'b00001;
  localparam logic [PFX_W-1:0] TEN_PFX = 5'b11110;

  typedef struct packed {
    logic clrCnt;
    logic shiftEn;
  } dpCtrlT;

  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic sclRise;
    logic sclFall;
    logic byteFull;
  } dpStatT;

  typedef enum logic [2:0] {
    S_IDLE, S_RECV, S_HOLD, S_ACKLO, S_ACKHI, S_SKIP
  } recStateT;
endpackage

// File: rtl/i2c_arec_dp.sv
module i2c_arec_dp
  import i2c_arec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtrlT            ctrl,
  output dpStatT            stat,
  output logic [BYTE_W-1:0] rxByte
);
  logic sclQ, sdaQ;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign stat.sclRise   = sclIn & ~sclQ;
  assign stat.sclFall   = ~sclIn & sclQ;
  assign stat.startSeen = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stat.stopSeen  = sclIn & sclQ & ~sdaQ & sdaIn;
  assign stat.byteFull  = (bitCnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else if (ctrl.clrCnt) begin
      bitCnt <= '0;
    end else if (ctrl.shiftEn && stat.sclRise && (bitCnt < CNT_W'(BYTE_W))) begin
      rxByte <= {rxByte[BYTE_W-2:0], sdaIn};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  a_r1_start_clears_count: assert property (@(posedge clk) disable iff (!rstN)
    stat.startSeen |=> (bitCnt == '0));
  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c_arec_ctl.sv
module i2c_arec_ctl
  import i2c_arec_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStatT            stat,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              tenBitMode,
  input  logic              genCallEn,
  output dpCtrlT            ctrl,
  output logic              ackDrive,
  output logic              matchP,
  output logic              gcallP,
  output logic              mcodeP,
  output logic              readDir
);
  recStateT state;
  logic secondByte, ackFlag, moreBytes, tenSel;

  logic isMc, isGc, isSeven, isTenHdr, isTenLow;
  assign isMc     = rxByte[BYTE_W-1 -: PFX_W] == MCODE_PFX;
  assign isGc     = genCallEn && (rxByte == '0);
  assign isSeven  = !tenBitMode && (rxByte[BYTE_W-1:1] == ownAddr[BYTE_W-2:0]);
  assign isTenHdr = tenBitMode && (rxByte[BYTE_W-1 -: PFX_W] == TEN_PFX)
                    && (rxByte[2:1] == ownAddr[ADDR_W-1 -: 2]);
  assign isTenLow = rxByte == ownAddr[BYTE_W-1:0];

  assign ctrl.shiftEn = (state == S_RECV);
  assign ctrl.clrCnt  = (state != S_RECV) || stat.startSeen;
  assign ackDrive     = ackFlag && ((state == S_ACKLO) || (state == S_ACKHI));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      secondByte <= 1'b0;
      ackFlag    <= 1'b0;
      moreBytes  <= 1'b0;
      tenSel     <= 1'b0;
      matchP     <= 1'b0;
      gcallP     <= 1'b0;
      mcodeP     <= 1'b0;
      readDir    <= 1'b0;
    end else begin
      matchP <= 1'b0;
      gcallP <= 1'b0;
      mcodeP <= 1'b0;
      if (stat.startSeen) begin
        state      <= S_RECV;
        secondByte <= 1'b0;
        ackFlag    <= 1'b0;
      end else if (stat.stopSeen) begin
        state   <= S_IDLE;
        tenSel  <= 1'b0;
        ackFlag <= 1'b0;
      end else begin
        unique case (state)
          S_RECV: if (stat.byteFull) begin
            state     <= S_HOLD;
            moreBytes <= 1'b0;
            ackFlag   <= 1'b0;
            if (!secondByte) begin
              tenSel <= 1'b0;
              if (isMc) begin
                mcodeP <= 1'b1;
              end else if (isGc) begin
                gcallP  <= 1'b1;
                ackFlag <= 1'b1;
                readDir <= 1'b0;
              end else if (isSeven) begin
                matchP  <= 1'b1;
                ackFlag <= 1'b1;
                readDir <= rxByte[0];
              end else if (isTenHdr && !rxByte[0]) begin
                ackFlag   <= 1'b1;
                moreBytes <= 1'b1;
              end else if (isTenHdr && rxByte[0] && tenSel) begin
                matchP  <= 1'b1;
                ackFlag <= 1'b1;
                readDir <= 1'b1;
                tenSel  <= 1'b1;
              end
            end else if (isTenLow) begin
              matchP  <= 1'b1;
              ackFlag <= 1'b1;
              readDir <= 1'b0;
              tenSel  <= 1'b1;
            end
          end
          S_HOLD:  if (stat.sclFall) state <= S_ACKLO;
          S_ACKLO: if (stat.sclRise) state <= S_ACKHI;
          S_ACKHI: if (stat.sclFall) begin
            if (moreBytes && ackFlag) begin
              state      <= S_RECV;
              secondByte <= 1'b1;
            end else begin
              state <= S_SKIP;
            end
          end
          default: state <= state;
        endcase
      end
    end
  end

  a_r8_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({matchP, gcallP, mcodeP}));
  a_r8_match_single: assert property (@(posedge clk) disable iff (!rstN)
    matchP |=> !matchP);
  a_r6_mcode_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    mcodeP |=> !ackDrive);
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stat.stopSeen |=> !ackDrive);
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
  import i2c_arec_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              tenBitMode,
  input  logic              genCallEn,
  output logic              sdaPullLow,
  output logic              addrMatch,
  output logic              genCallHit,
  output logic              masterCodeHit,
  output logic              readDir
);
  dpCtrlT ctrl;
  dpStatT stat;
  logic [BYTE_W-1:0] rxByte;

  i2c_arec_dp u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctrl(ctrl), .stat(stat), .rxByte(rxByte)
  );

  i2c_arec_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .rxByte(rxByte),
    .ownAddr(ownAddr), .tenBitMode(tenBitMode), .genCallEn(genCallEn),
    .ctrl(ctrl), .ackDrive(sdaPullLow), .matchP(addrMatch),
    .gcallP(genCallHit), .mcodeP(masterCodeHit), .readDir(readDir)
  );

  a_r7_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn);
endmodule

// File: tb/sim_i2c_addr_recog.sv
module sim_i2c_addr_recog;
  localparam int H = 5;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic [9:0] ownAddr = '0;
  logic tenBitMode = 1'b0, genCallEn = 1'b0;
  logic sdaPullLow, addrMatch, genCallHit, masterCodeHit, readDir;
  logic sdaBus;
  int total = 0, bad = 0;
  int nMatch = 0, nGc = 0, nMc = 0, stray = 0;
  logic inAckSlot = 1'b0;

  always #5 clk = ~clk;
  assign sdaBus = sdaDrv & ~sdaPullLow;

  i2c_addr_recog u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus),
    .ownAddr(ownAddr), .tenBitMode(tenBitMode), .genCallEn(genCallEn),
    .sdaPullLow(sdaPullLow), .addrMatch(addrMatch), .genCallHit(genCallHit),
    .masterCodeHit(masterCodeHit), .readDir(readDir)
  );

  always @(negedge clk) begin
    if (addrMatch) nMatch++;
    if (genCallHit) nGc++;
    if (masterCodeHit) nMc++;
    if (sdaPullLow && !inAckSlot) stray++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (H) @(negedge clk);
  endtask

  task automatic clrEv();
    nMatch = 0; nGc = 0; nMc = 0;
  endtask

  task automatic doStart();
    sdaDrv = 1'b1; waitH();
    sclDrv = 1'b1; waitH();
    sdaDrv = 1'b0; waitH();
    sclDrv = 1'b0; waitH();
  endtask

  task automatic doStop();
    sdaDrv = 1'b0; waitH();
    sclDrv = 1'b1; waitH();
    sdaDrv = 1'b1; waitH();
  endtask

  task automatic doBit(input logic b);
    sdaDrv = b; waitH();
    sclDrv = 1'b1; waitH();
    sclDrv = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output int ack);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) begin
        sdaDrv = b[0]; waitH();
        sclDrv = 1'b1; waitH();
        sclDrv = 1'b0;
        inAckSlot = 1'b1;
      end else begin
        doBit(b[i]);
      end
    end
    sdaDrv = 1'b1; waitH();
    sclDrv = 1'b1;
    repeat (2) @(negedge clk);
    ack = sdaBus ? 0 : 1;
    repeat (H - 2) @(negedge clk);
    sclDrv = 1'b0;
    @(negedge clk);
    inAckSlot = 1'b0;
    waitH();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ack, ack2;
    logic [6:0] own7;
    logic [9:0] own10;
    own7 = 7'h5A;
    own10 = 10'h2C5;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pull", int'(sdaPullLow), 0);
    chk("R10 events", int'(addrMatch | genCallHit | masterCodeHit), 0);
    chk("R10 readDir", int'(readDir), 0);
    rstN = 1'b1;
    waitH();

    // 7-bit sweep with general call enabled: R2 R5 R6 R11 R8
    ownAddr = {3'b000, own7}; tenBitMode = 1'b0; genCallEn = 1'b1;
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      bb = 8'(b);
      clrEv();
      doStart(); sendByte(bb, ack); doStop();
      chk($sformatf("R2/R5/R6/R11 ack byte %0h", b), ack,
          int'((bb[7:1] == own7) || (bb == 8'h00)));
      chk($sformatf("R2/R8 match byte %0h", b), nMatch, int'(bb[7:1] == own7));
      chk($sformatf("R5 gcall byte %0h", b), nGc, int'(bb == 8'h00));
      chk($sformatf("R6 mcode byte %0h", b), nMc, int'(bb[7:3] == 5'b00001));
      if (bb[7:1] == own7) chk("R2 readDir", int'(readDir), int'(bb[0]));
    end

    // R5 general call disabled
    genCallEn = 1'b0; clrEv();
    doStart(); sendByte(8'h00, ack); doStop();
    chk("R5 gc off ack", ack, 0);
    chk("R5 gc off event", nGc + nMatch, 0);

    // R11 later bytes ignored after a non-matching first byte
    clrEv();
    doStart(); sendByte(8'h22, ack); sendByte({own7, 1'b0}, ack2); doStop();
    chk("R11 first nack", ack, 0);
    chk("R11 later byte ignored", ack2, 0);
    chk("R11 no event", nMatch, 0);

    // R9 repeated START inside a byte
    clrEv();
    doStart(); doBit(1'b1); doBit(1'b0); doBit(1'b1); doBit(1'b1);
    doStart(); sendByte({own7, 1'b1}, ack); doStop();
    chk("R9 restart ack", ack, 1);
    chk("R9 restart match", nMatch, 1);
    chk("R9 readDir", int'(readDir), 1);

    // 10-bit sweep of the second byte: R3
    ownAddr = own10; tenBitMode = 1'b1; genCallEn = 1'b1;
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      bb = 8'(b);
      clrEv();
      doStart(); sendByte({5'b11110, own10[9:8], 1'b0}, ack); sendByte(bb, ack2); doStop();
      chk("R3 header ack", ack, 1);
      chk($sformatf("R3 low byte ack %0h", b), ack2, int'(bb == own10[7:0]));
      chk($sformatf("R3 match %0h", b), nMatch, int'(bb == own10[7:0]));
      if (bb == own10[7:0]) chk("R3 readDir", int'(readDir), 0);
    end

    // R3 wrong upper bits in header, 7-bit pattern in 10-bit mode
    clrEv();
    doStart(); sendByte({5'b11110, ~own10[9:8], 1'b0}, ack); doStop();
    chk("R3 wrong header nack", ack, 0);
    doStart(); sendByte({own7, 1'b0}, ack); doStop();
    chk("R3 seven-bit pattern nack", ack, 0);
    chk("R3 no event", nMatch, 0);

    // R4 read re-select after repeated START
    clrEv();
    doStart(); sendByte({5'b11110, own10[9:8], 1'b0}, ack); sendByte(own10[7:0], ack2);
    doStart(); sendByte({5'b11110, own10[9:8], 1'b1}, ack); doStop();
    chk("R4 reselect ack", ack, 1);
    chk("R4 match count", nMatch, 2);
    chk("R4 readDir", int'(readDir), 1);
    clrEv();
    doStart(); sendByte({5'b11110, own10[9:8], 1'b1}, ack); doStop();
    chk("R4 after stop nack", ack, 0);
    chk("R4 after stop no event", nMatch, 0);

    // R6 master code in 10-bit mode, R1 idle after stop
    clrEv();
    doStart(); sendByte(8'h0B, ack); doStop();
    chk("R6 mcode nack", ack, 0);
    chk("R6 mcode event", nMc, 1);
    chk("R1 idle release", int'(sdaPullLow), 0);

    // R7 pull-low only inside the acknowledge slot
    chk("R7 stray pull cycles", stray, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule